// File: doc/BRIEF.md
# Transaction Sequence Compliance Monitor

This block is a synthesizable protocol checker. It watches six single-bit control signals of a bus-style interface and decides whether each armed transaction has the required shape. A check is armed by a three-cycle pattern: a request, then an acknowledge in the next cycle, then a cycle with cancel low. From then on the monitor expects a start marker in the very next cycle. It then expects a bounded, not necessarily contiguous, run of data-valid beats, closed by an end marker.

Every outcome is reported on registered outputs, one cycle after the cycle that decided it. A legal transaction gives a one-cycle pass pulse. A violation gives a one-cycle error pulse with a reason code and sets a sticky error flag. In both cases the monitor goes back to waiting for the next arming pattern. Only one check can be in flight at a time. All pins are plain control and status signals; the block has no data path and no valid/ready interface, so it never exerts back-pressure.

Top module: `txn_shape_monitor`

## Requirements
- R1: A check is armed only when `req` is high in some cycle n, `ack` is high in cycle n+1 and `cancel` is low in cycle n+2. If `cancel` is high in n+2, or `ack` is low in n+1, nothing is armed and no output pulses follow.
- R2: An armed check requires `start_trans` high in cycle n+3. If it is low, the monitor reports reason code 1 and returns to idle.
- R3: After the start cycle, any number of `data_valid` beats from 1 to MAX_BEATS (default 8), with any gaps shorter than the idle limit, followed by `write_end` gives `pass_pulse` high for exactly one cycle. The pulse appears in the cycle after the `write_end` cycle, and `err_code` stays 0.
- R4: A `data_valid` beat arriving when MAX_BEATS beats have already been counted reports reason code 2.
- R5: `write_end` arriving with zero counted beats reports reason code 3. A `data_valid` in the start cycle is not counted, and neither is one in the same cycle as `write_end`.
- R6: IDLE_LIMIT (default 64) consecutive cycles after the start cycle in which both `data_valid` and `write_end` are low report reason code 4. Each `data_valid` beat restarts this count.
- R7: An arming pattern that completes while a check is in flight is ignored. It neither restarts nor aborts the check, and it raises no reason code 1 later.
- R8: Each violation raises `err_pulse` for one cycle, in the cycle after the deciding cycle, with `err_code` holding the reason. `err_code` is 0 whenever `err_pulse` is low. `err_sticky` rises with the first error and stays high until reset. Checking continues after an error.
- R9: Synchronous reset (`rst` high) clears the sequence state, the counters, the pending arming history and all outputs, `err_sticky` included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request observed on the interface |
| ack | input | 1 | Acknowledge observed on the interface |
| cancel | input | 1 | Cancel observed on the interface |
| start_trans | input | 1 | Transaction start marker |
| data_valid | input | 1 | Data beat marker |
| write_end | input | 1 | Transaction end marker |
| err_sticky | output | 1 | Set by any violation, cleared only by reset |
| err_pulse | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Reason: 1 no start, 2 too many beats, 3 no beats, 4 idle timeout; 0 otherwise |
| pass_pulse | output | 1 | One-cycle pulse for a legal transaction |

## Verification
The bench builds the monitor with MAX_BEATS = 4 and IDLE_LIMIT = 5. With these values every legal beat count can be swept against every gap length from 0 to 3 in a short run. The overflow beat and the watchdog expiry also sit only a few cycles away, so the boundary cases come at small, computable offsets. The gap sweep keeps each gap below the idle limit, so it shows that beats restart the watchdog. Directed cases add a cancelled arming, a missing acknowledge, a missing start, an empty transaction, an overlapping arming pattern, and reset in the middle of a transaction.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } tsm_state_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_NO_START = 3'd1,
    RSN_OVERFLOW = 3'd2,
    RSN_EMPTY    = 3'd3,
    RSN_STALL    = 3'd4
  } tsm_reason_e;
endpackage

// File: rtl/tsm_trigger_det.sv
module tsm_trigger_det (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack,
  input  logic cancel,
  output logic armed
);
  logic saw_req_q;
  logic saw_req_ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      saw_req_q     <= 1'b0;
      saw_req_ack_q <= 1'b0;
    end else begin
      saw_req_q     <= req;
      saw_req_ack_q <= saw_req_q & ack;
    end
  end

  assign armed = saw_req_ack_q & ~cancel;

  // R1: arming only follows req two cycles back and ack one cycle back
  p_arm_shape_r1: assert property (@(posedge clk) disable iff (rst)
    armed |-> ($past(ack) && $past(req, 2) && !cancel));
endmodule

// File: rtl/tsm_beat_counter.sv
module tsm_beat_counter #(
  parameter int MAX_BEATS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_max,
  output logic is_zero
);
  localparam int CW = $clog2(MAX_BEATS + 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
    end else if (inc && !at_max) begin
      count_q <= count_q + CW'(1);
    end
  end

  assign at_max  = (count_q == CW'(MAX_BEATS));
  assign is_zero = (count_q == '0);

  // R4: the beat count never passes the configured maximum
  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(MAX_BEATS));
endmodule

// File: rtl/tsm_idle_watchdog.sv
module tsm_idle_watchdog #(
  parameter int IDLE_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic kick,
  output logic expire
);
  localparam int WW = $clog2(IDLE_LIMIT + 1);

  logic [WW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst || !run || kick) begin
      idle_q <= '0;
    end else if (!expire) begin
      idle_q <= idle_q + WW'(1);
    end
  end

  assign expire = run & ~kick & (idle_q == WW'(IDLE_LIMIT - 1));

  // R6: the idle count stays below the limit
  p_idle_bound_r6: assert property (@(posedge clk) disable iff (rst)
    idle_q < WW'(IDLE_LIMIT));
endmodule

// File: rtl/txn_shape_monitor.sv
module txn_shape_monitor #(
  parameter int MAX_BEATS  = 8,
  parameter int IDLE_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       ack,
  input  logic       cancel,
  input  logic       start_trans,
  input  logic       data_valid,
  input  logic       write_end,
  output logic       err_sticky,
  output logic       err_pulse,
  output logic [2:0] err_code,
  output logic       pass_pulse
);
  import tsm_pkg::*;

  tsm_state_e  state_q, state_d;
  tsm_reason_e reason_d;
  logic        armed;
  logic        flag_err, flag_pass;
  logic        beat_inc, at_max, is_zero;
  logic        stall;

  tsm_trigger_det u_trig (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .ack    (ack),
    .cancel (cancel),
    .armed  (armed)
  );

  tsm_beat_counter #(.MAX_BEATS(MAX_BEATS)) u_beats (
    .clk     (clk),
    .rst     (rst),
    .clr     (state_q != ST_DATA),
    .inc     (beat_inc),
    .at_max  (at_max),
    .is_zero (is_zero)
  );

  tsm_idle_watchdog #(.IDLE_LIMIT(IDLE_LIMIT)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .run    (state_q == ST_DATA),
    .kick   (data_valid | write_end),
    .expire (stall)
  );

  always_comb begin
    state_d   = state_q;
    reason_d  = RSN_NONE;
    flag_err  = 1'b0;
    flag_pass = 1'b0;
    beat_inc  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (armed) state_d = ST_START;
      end
      ST_START: begin
        if (start_trans) begin
          state_d = ST_DATA;
        end else begin
          flag_err = 1'b1;
          reason_d = RSN_NO_START;
          state_d  = ST_IDLE;
        end
      end
      ST_DATA: begin
        if (write_end) begin
          state_d = ST_IDLE;
          if (is_zero) begin
            flag_err = 1'b1;
            reason_d = RSN_EMPTY;
          end else begin
            flag_pass = 1'b1;
          end
        end else if (data_valid) begin
          if (at_max) begin
            flag_err = 1'b1;
            reason_d = RSN_OVERFLOW;
            state_d  = ST_IDLE;
          end else begin
            beat_inc = 1'b1;
          end
        end else if (stall) begin
          flag_err = 1'b1;
          reason_d = RSN_STALL;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      err_pulse  <= 1'b0;
      err_code   <= 3'd0;
      err_sticky <= 1'b0;
      pass_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      err_pulse  <= flag_err;
      err_code   <= flag_err ? reason_d : RSN_NONE;
      err_sticky <= err_sticky | flag_err;
      pass_pulse <= flag_pass;
    end
  end

  // R8: pass and error never pulse together
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(err_pulse && pass_pulse));
  // R8: sticky flag holds until reset
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);
  // R8: reason code is non-zero exactly with the pulse
  p_code_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (err_code != 3'd0) == err_pulse);
  // R8: every error pulse is reflected in the sticky flag
  p_pulse_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> err_sticky);
  // R3: a pass always follows an end marker
  p_pass_end_r3: assert property (@(posedge clk) disable iff (rst)
    pass_pulse |-> $past(write_end));
  // R2: reason 1 only when start was absent
  p_nostart_r2: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && err_code == 3'd1) |-> $past(!start_trans));
  // R7: arming while busy leaves the state untouched
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && armed && !data_valid && !write_end && !stall)
      |=> state_q == ST_DATA);
endmodule

// File: tb/txn_shape_monitor_tb.sv
module txn_shape_monitor_tb;
  localparam int MAXB = 4;
  localparam int LIM  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, ack = 1'b0, cancel = 1'b0;
  logic start_trans = 1'b0, data_valid = 1'b0, write_end = 1'b0;
  logic err_sticky, err_pulse, pass_pulse;
  logic [2:0] err_code;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  txn_shape_monitor #(.MAX_BEATS(MAXB), .IDLE_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .req(req), .ack(ack), .cancel(cancel),
    .start_trans(start_trans), .data_valid(data_valid), .write_end(write_end),
    .err_sticky(err_sticky), .err_pulse(err_pulse), .err_code(err_code),
    .pass_pulse(pass_pulse)
  );

  task automatic step(input logic r, a, c, s, d, w);
    @(negedge clk);
    req = r; ack = a; cancel = c; start_trans = s; data_valid = d; write_end = w;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic arm();
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_out(input string tag, input logic ep, input logic [2:0] ec,
                            input logic pp);
    checks++;
    if (err_pulse !== ep || err_code !== ec || pass_pulse !== pp) begin
      errors++;
      $display("FAIL %s: got err_pulse=%0b code=%0d pass=%0b, expected %0b %0d %0b",
               tag, err_pulse, err_code, pass_pulse, ep, ec, pp);
    end
  endtask

  task automatic expect_sticky(input string tag, input logic v);
    checks++;
    if (err_sticky !== v) begin
      errors++;
      $display("FAIL %s: got err_sticky=%0b, expected %0b", tag, err_sticky, v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle(); idle();
    expect_out("R9 reset outputs", 0, 0, 0);
    expect_sticky("R9 reset sticky", 0);
    rst = 1'b0;
    idle();

    // R3 sweep: every legal beat count against gaps 0..3 (below LIM)
    for (int n = 1; n <= MAXB; n++) begin
      for (int g = 0; g <= 3; g++) begin
        arm();
        expect_out("R1 arming quiet", 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        for (int k = 0; k < n; k++) begin
          for (int i = 0; i < g; i++) idle();
          step(0, 0, 0, 0, 1, 0);
          expect_out("R3 beat quiet", 0, 0, 0);
        end
        step(0, 0, 0, 0, 0, 1);
        expect_out("R3 pass", 0, 0, 1);
        idle();
        expect_out("R3 single pulse", 0, 0, 0);
      end
    end
    expect_sticky("R8 no error after passes", 0);

    // R6: gaps of LIM-1 still pass, since beats restart the count
    arm(); step(0, 0, 0, 1, 0, 0);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < LIM - 1; i++) idle();
      step(0, 0, 0, 0, 1, 0);
    end
    for (int i = 0; i < LIM - 1; i++) idle();
    expect_out("R6 no early stall", 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    expect_out("R6 restart pass", 0, 0, 1);

    // R1: cancel high -> nothing armed, no missing-start error
    step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0);
    idle(); idle();
    expect_out("R1 cancel blocks", 0, 0, 0);
    // R1: no ack -> nothing armed
    step(1, 0, 0, 0, 0, 0); idle(); idle(); idle(); idle();
    expect_out("R1 missing ack", 0, 0, 0);
    expect_sticky("R1 sticky clear", 0);

    // R2: missing start
    arm(); idle();
    expect_out("R2 no start code1", 1, 1, 0);
    expect_sticky("R8 sticky set", 1);
    idle();
    expect_out("R8 one-cycle error", 0, 0, 0);
    expect_sticky("R8 sticky holds", 1);

    // R4: overflow beat
    arm(); step(0, 0, 0, 1, 0, 0);
    for (int k = 0; k < MAXB; k++) step(0, 0, 0, 0, 1, 0);
    expect_out("R4 max beats quiet", 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    expect_out("R4 overflow code2", 1, 2, 0);
    idle();
    expect_out("R4 back to idle", 0, 0, 0);

    // R5: empty, data_valid in start cycle not counted
    arm(); step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    expect_out("R5 empty code3", 1, 3, 0);
    // R5: data_valid with write_end not counted
    arm(); step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    expect_out("R5 end-cycle beat code3", 1, 3, 0);

    // R6: stall
    arm(); step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < LIM - 1; i++) idle();
    expect_out("R6 before limit", 0, 0, 0);
    idle();
    expect_out("R6 stall code4", 1, 4, 0);

    // R7: overlapping arming ignored; R8: checking continues after error
    arm(); step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    expect_out("R7 pass despite overlap", 0, 0, 1);
    idle(); idle();
    expect_out("R7 no late code1", 0, 0, 0);
    expect_sticky("R8 sticky still set", 1);

    // R9: reset mid-transaction clears everything
    arm();
    rst = 1'b1;
    idle();
    rst = 1'b0;
    expect_out("R9 reset outputs mid", 0, 0, 0);
    expect_sticky("R9 reset clears sticky", 0);
    idle(); idle();
    expect_out("R9 arming history cleared", 0, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule